// File: doc/BRIEF.md
# Synthesizer Loop Divider and Phase Detector

This block is the digital core of an integer-N frequency synthesizer. It takes two tick streams, both one system-clock cycle wide. One comes from the tuned oscillator after an external fixed divide-by-8 stage. The other comes from the reference oscillator. The block divides each stream by its own ratio. A phase-frequency detector compares the two divided pulse trains and asks the charge pump to push the tuning voltage up or down. When the loop is locked, the oscillator runs at 8 × N × f_ref / R. With a 4 MHz reference and R = 512, the comparison rate is 7.8125 kHz and the output step is 62.5 kHz.

Control inputs set the following:
- the 15-bit oscillator ratio N;
- the reference ratio R, either taken from a two-bit select or fixed at the nominal value;
- the pump current level;
- a pump hold flag;
- a loop-open flag that also drops the pump driver enable;
- a test flag that brings both divided pulse trains out on dedicated pins, for production checks.

Top module: `synthCore`

## Requirements
- R1: During reset and in the first cycle after it, pumpUp, pumpDn, testDivOut and testRefOut are 0.
- R2: The oscillator divider produces one pulse for every N ticks of vcoTick. The pulse shows on testDivOut (when divTest=1) in the cycle after the tick that completes the count. The first tick after reset always completes a count. N=0 behaves like N=1.
- R3: A change of divRatio is taken only at a terminal count. The period in progress finishes with the old ratio.
- R4: The reference divider behaves like R2, on refTick, and shows on testRefOut. When selEnable=1, refSel gives R: 0 gives the nominal R, 1 gives twice the nominal, 2 gives half the nominal, and 3 gives the nominal. When selEnable=0, R is the nominal value. A new R is taken only at a reference terminal count.
- R5: The detector sets its up state on a divided reference pulse and its down state on a divided oscillator pulse. Each shows on pumpUp/pumpDn in the cycle after that pulse. When the opposite pulse arrives, both states clear, and pulses that arrive together leave both clear.
- R6: pumpUp and pumpDn are never 1 in the same cycle.
- R7: pumpHold=1 forces pumpUp and pumpDn to 0. It leaves driveEnable at 1 and keeps the detector state, which shows again when the hold is released.
- R8: loopOpen=1 forces pumpUp, pumpDn and driveEnable to 0.
- R9: When divTest=0, testDivOut and testRefOut are 0.
- R10: pumpHigh follows curSel when selEnable=1 and is 1 when selEnable=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| vcoTick | input | 1 | One-cycle tick from the prescaled oscillator |
| refTick | input | 1 | One-cycle tick from the reference oscillator |
| divRatio | input | 15 | Oscillator divider ratio N |
| selEnable | input | 1 | 1: refSel and curSel are honoured |
| refSel | input | 2 | Reference ratio select |
| curSel | input | 1 | Pump current select, 1 is high |
| pumpHold | input | 1 | Hold pump outputs inactive |
| divTest | input | 1 | Route divided pulses to test outputs |
| loopOpen | input | 1 | Disable pump driver and open the loop |
| pumpUp | output | 1 | Pump up request |
| pumpDn | output | 1 | Pump down request |
| pumpHigh | output | 1 | Pump current level |
| driveEnable | output | 1 | Pump driver enable |
| testDivOut | output | 1 | Divided oscillator pulse in test mode |
| testRefOut | output | 1 | Divided reference pulse in test mode |

## Verification
The bench changes the oscillator ratio in the middle of a period. A divider that reloads at once would produce a short period, and the check on the first pulse spacing after the change would catch it. Every reference select value is exercised, together with the fixed mode. A wrong decode, or a ratio taken before the terminal count, shifts the testRefOut pulses away from the expected cycle.

Random tick streams make the two divided pulses arrive together. A detector that set both outputs at once, or that lost its state while held, would show on pumpUp/pumpDn after the hold is released. Ratio 0 and ratio 1 are driven to catch a divider that stalls at the bottom of its count.

// File: rtl/synthPkg.sv
package synthPkg;
  // Gating strobes from the control section to the datapath.
  typedef struct packed {
    logic pumpAllow;
    logic driveOn;
    logic testOn;
    logic highCurrent;
  } synthStrobes_t;
endpackage

// File: rtl/synthCtrl.sv
module synthCtrl
  import synthPkg::*;
#(
  parameter int REF_NOM = 512,
  parameter int REF_W   = $clog2(REF_NOM) + 2
) (
  input  logic             selEnable,
  input  logic [1:0]       refSel,
  input  logic             curSel,
  input  logic             pumpHold,
  input  logic             divTest,
  input  logic             loopOpen,
  output synthStrobes_t    strobes,
  output logic [REF_W-1:0] refRatio
);
  localparam logic [REF_W-1:0] NOM_R  = REF_W'(REF_NOM);
  localparam logic [REF_W-1:0] DBL_R  = REF_W'(REF_NOM * 2);
  localparam logic [REF_W-1:0] HALF_R = REF_W'(REF_NOM / 2);

  always_comb begin
    strobes.pumpAllow   = !pumpHold && !loopOpen;
    strobes.driveOn     = !loopOpen;
    strobes.testOn      = divTest;
    strobes.highCurrent = selEnable ? curSel : 1'b1;
  end

  always_comb begin
    refRatio = NOM_R;
    if (selEnable) begin
      unique case (refSel)
        2'd1:    refRatio = DBL_R;
        2'd2:    refRatio = HALF_R;
        default: refRatio = NOM_R;
      endcase
    end
  end
endmodule

// File: rtl/synthDivider.sv
module synthDivider #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] ratio,
  output logic         pulse
);
  logic [W-1:0] cnt;

  // Counts down; the ratio is sampled only when a count completes.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else if (tick) begin
      if (cnt < W'(2)) begin
        cnt   <= ratio;
        pulse <= 1'b1;
      end else begin
        cnt   <= cnt - W'(1);
        pulse <= 1'b0;
      end
    end else begin
      pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/synthPfd.sv
module synthPfd (
  input  logic clk,
  input  logic rst,
  input  logic refPulse,
  input  logic divPulse,
  output logic upQ,
  output logic dnQ
);
  logic upNext;
  logic dnNext;

  always_comb begin
    upNext = upQ || refPulse;
    dnNext = dnQ || divPulse;
    if (upNext && dnNext) begin
      upNext = 1'b0;
      dnNext = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upQ <= 1'b0;
      dnQ <= 1'b0;
    end else begin
      upQ <= upNext;
      dnQ <= dnNext;
    end
  end
endmodule

// File: rtl/synthDatapath.sv
module synthDatapath
  import synthPkg::*;
#(
  parameter int RATIO_W = 15,
  parameter int REF_W   = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               vcoTick,
  input  logic               refTick,
  input  logic [RATIO_W-1:0] divRatio,
  input  logic [REF_W-1:0]   refRatio,
  input  synthStrobes_t      strobes,
  output logic               pumpUp,
  output logic               pumpDn,
  output logic               pumpHigh,
  output logic               driveEnable,
  output logic               testDivOut,
  output logic               testRefOut
);
  logic divPulse;
  logic refPulse;
  logic upQ;
  logic dnQ;

  synthDivider #(.W(RATIO_W)) u_vcoDiv (
    .clk(clk), .rst(rst), .tick(vcoTick), .ratio(divRatio), .pulse(divPulse)
  );

  synthDivider #(.W(REF_W)) u_refDiv (
    .clk(clk), .rst(rst), .tick(refTick), .ratio(refRatio), .pulse(refPulse)
  );

  synthPfd u_pfd (
    .clk(clk), .rst(rst), .refPulse(refPulse), .divPulse(divPulse),
    .upQ(upQ), .dnQ(dnQ)
  );

  always_comb begin
    pumpUp      = upQ && strobes.pumpAllow;
    pumpDn      = dnQ && strobes.pumpAllow;
    pumpHigh    = strobes.highCurrent;
    driveEnable = strobes.driveOn;
    testDivOut  = divPulse && strobes.testOn;
    testRefOut  = refPulse && strobes.testOn;
  end
endmodule

// File: rtl/synthCore.sv
module synthCore
  import synthPkg::*;
#(
  parameter int RATIO_W = 15,
  parameter int REF_NOM = 512
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               vcoTick,
  input  logic               refTick,
  input  logic [RATIO_W-1:0] divRatio,
  input  logic               selEnable,
  input  logic [1:0]         refSel,
  input  logic               curSel,
  input  logic               pumpHold,
  input  logic               divTest,
  input  logic               loopOpen,
  output logic               pumpUp,
  output logic               pumpDn,
  output logic               pumpHigh,
  output logic               driveEnable,
  output logic               testDivOut,
  output logic               testRefOut
);
  localparam int REF_W = $clog2(REF_NOM) + 2;

  synthStrobes_t    strobes;
  logic [REF_W-1:0] refRatio;

  synthCtrl #(.REF_NOM(REF_NOM), .REF_W(REF_W)) u_ctrl (
    .selEnable(selEnable), .refSel(refSel), .curSel(curSel),
    .pumpHold(pumpHold), .divTest(divTest), .loopOpen(loopOpen),
    .strobes(strobes), .refRatio(refRatio)
  );

  synthDatapath #(.RATIO_W(RATIO_W), .REF_W(REF_W)) u_dp (
    .clk(clk), .rst(rst), .vcoTick(vcoTick), .refTick(refTick),
    .divRatio(divRatio), .refRatio(refRatio), .strobes(strobes),
    .pumpUp(pumpUp), .pumpDn(pumpDn), .pumpHigh(pumpHigh),
    .driveEnable(driveEnable), .testDivOut(testDivOut), .testRefOut(testRefOut)
  );
endmodule

// File: rtl/synthCoreChecker.sv
module synthCoreChecker (
  input logic clk,
  input logic rst,
  input logic vcoTick,
  input logic refTick,
  input logic selEnable,
  input logic pumpHold,
  input logic divTest,
  input logic loopOpen,
  input logic pumpUp,
  input logic pumpDn,
  input logic pumpHigh,
  input logic driveEnable,
  input logic testDivOut,
  input logic testRefOut
);
  a_r6_never_both: assert property (@(posedge clk) disable iff (rst)
    !(pumpUp && pumpDn));

  a_r8_open_loop: assert property (@(posedge clk) disable iff (rst)
    loopOpen |-> (!pumpUp && !pumpDn && !driveEnable));

  a_r7_hold_pumps: assert property (@(posedge clk) disable iff (rst)
    (pumpHold && !loopOpen) |-> (!pumpUp && !pumpDn && driveEnable));

  a_r9_test_quiet: assert property (@(posedge clk) disable iff (rst)
    !divTest |-> (!testDivOut && !testRefOut));

  a_r2_div_after_tick: assert property (@(posedge clk) disable iff (rst)
    testDivOut |-> $past(vcoTick));

  a_r4_ref_after_tick: assert property (@(posedge clk) disable iff (rst)
    testRefOut |-> $past(refTick));

  a_r10_high_default: assert property (@(posedge clk) disable iff (rst)
    !selEnable |-> pumpHigh);
endmodule

bind synthCore synthCoreChecker u_synthCoreChecker (
  .clk(clk), .rst(rst), .vcoTick(vcoTick), .refTick(refTick),
  .selEnable(selEnable), .pumpHold(pumpHold), .divTest(divTest),
  .loopOpen(loopOpen), .pumpUp(pumpUp), .pumpDn(pumpDn),
  .pumpHigh(pumpHigh), .driveEnable(driveEnable),
  .testDivOut(testDivOut), .testRefOut(testRefOut)
);

// File: tb/test_synthCore.sv
`timescale 1ns/1ps
module test_synthCore;
  localparam int RATIO_W = 15;
  localparam int REF_NOM = 8;

  logic clk = 1'b0;
  logic rst;
  logic vcoTick, refTick;
  logic [RATIO_W-1:0] divRatio;
  logic selEnable, curSel, pumpHold, divTest, loopOpen;
  logic [1:0] refSel;
  logic pumpUp, pumpDn, pumpHigh, driveEnable, testDivOut, testRefOut;

  int checks = 0;
  int errors = 0;
  string divTag = "R2";
  string refTag = "R4";

  // Reference model state
  int  mCnt, mRcnt;
  bit  mDivP, mRefP, mUp, mDn;

  always #2.5 clk = ~clk;

  synthCore #(.RATIO_W(RATIO_W), .REF_NOM(REF_NOM)) i_synthCore (
    .clk(clk), .rst(rst), .vcoTick(vcoTick), .refTick(refTick),
    .divRatio(divRatio), .selEnable(selEnable), .refSel(refSel),
    .curSel(curSel), .pumpHold(pumpHold), .divTest(divTest),
    .loopOpen(loopOpen), .pumpUp(pumpUp), .pumpDn(pumpDn),
    .pumpHigh(pumpHigh), .driveEnable(driveEnable),
    .testDivOut(testDivOut), .testRefOut(testRefOut)
  );

  function automatic int expRefRatio(bit en, logic [1:0] sel);
    if (!en) return REF_NOM;
    case (sel)
      2'd1:    return REF_NOM * 2;
      2'd2:    return REF_NOM / 2;
      default: return REF_NOM;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    bit eUp, eDn;
    string pTag;
    eUp = mUp && !pumpHold && !loopOpen;
    eDn = mDn && !pumpHold && !loopOpen;
    pTag = loopOpen ? "R8" : (pumpHold ? "R7" : "R5");
    chk(pumpUp == eUp, pTag, "pumpUp", pumpUp, eUp);
    chk(pumpDn == eDn, pTag, "pumpDn", pumpDn, eDn);
    chk(!(pumpUp && pumpDn), "R6", "up&dn", 1, 0);
    chk(driveEnable == !loopOpen, "R8", "driveEnable", driveEnable, !loopOpen);
    chk(pumpHigh == (selEnable ? curSel : 1'b1), "R10", "pumpHigh", pumpHigh,
        selEnable ? curSel : 1'b1);
    chk(testDivOut == (mDivP && divTest), divTest ? divTag : "R9", "testDivOut",
        testDivOut, mDivP && divTest);
    chk(testRefOut == (mRefP && divTest), divTest ? refTag : "R9", "testRefOut",
        testRefOut, mRefP && divTest);
  endtask

  task automatic advance(bit v, bit r);
    bit nUp, nDn;
    int rr;
    nUp = mUp || mRefP;
    nDn = mDn || mDivP;
    if (nUp && nDn) begin nUp = 0; nDn = 0; end
    mUp = nUp; mDn = nDn;
    mDivP = v && (mCnt < 2);
    if (v) mCnt = (mCnt < 2) ? int'(divRatio) : mCnt - 1;
    rr = expRefRatio(selEnable, refSel);
    mRefP = r && (mRcnt < 2);
    if (r) mRcnt = (mRcnt < 2) ? rr : mRcnt - 1;
  endtask

  task automatic doCycle(bit v, bit r);
    vcoTick = v; refTick = r;
    #1;
    compareAll();
    @(posedge clk);
    advance(v, r);
    @(negedge clk);
  endtask

  // Count cycles between divided-oscillator pulses with ticks every cycle.
  task automatic measureDivGap(int expGap, string tag);
    int gap;
    gap = 0;
    do begin doCycle(1, 0); gap++; end while (!testDivOut && gap < 200);
    chk(gap == expGap, tag, "pulse spacing", gap, expGap);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    rst = 1; vcoTick = 0; refTick = 0; divRatio = 15'd5;
    selEnable = 1; refSel = 0; curSel = 0; pumpHold = 0; divTest = 1; loopOpen = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(!pumpUp && !pumpDn && !testDivOut && !testRefOut, "R1", "outputs in reset",
        {pumpUp, pumpDn, testDivOut, testRefOut}, 0);
    @(negedge clk);
    rst = 0;
    mCnt = 0; mRcnt = 0; mDivP = 0; mRefP = 0; mUp = 0; mDn = 0;
    #1;
    chk(!pumpUp && !pumpDn && !testDivOut && !testRefOut, "R1", "outputs after reset",
        {pumpUp, pumpDn, testDivOut, testRefOut}, 0);

    // R2: first tick completes a count, then period 5
    measureDivGap(1, "R2");
    measureDivGap(5, "R2");
    measureDivGap(5, "R2");
    // R3: change ratio mid-period; old period finishes, then new one
    divTag = "R3";
    doCycle(1, 0); doCycle(1, 0);
    divRatio = 15'd3;
    measureDivGap(3, "R3");   // remaining 3 of the old 5
    measureDivGap(3, "R3");
    divRatio = 15'd0;          // R2 ratio 0 acts as 1
    divTag = "R2";
    measureDivGap(3, "R2");
    measureDivGap(1, "R2");
    divRatio = 15'd1;
    measureDivGap(1, "R2");

    // R4: each reference select value and fixed mode
    refTag = "R4";
    for (int s = 0; s < 5; s++) begin
      selEnable = (s < 4);
      refSel = 2'(s);
      repeat (3 * REF_NOM * 2) doCycle(0, 1);
    end
    selEnable = 1;

    // R5/R7: drive pulses, hold, release
    divRatio = 15'd4;
    repeat (60) doCycle(1, ($urandom % 2) == 0);
    pumpHold = 1;
    repeat (40) doCycle(($urandom % 3) == 0, 1);
    pumpHold = 0;
    repeat (20) doCycle(0, 0);

    // Random phase
    for (int blk = 0; blk < 40; blk++) begin
      int pv, pr;
      divRatio  = RATIO_W'($urandom % 24);
      selEnable = $urandom % 2;
      refSel    = 2'($urandom % 4);
      curSel    = $urandom % 2;
      pumpHold  = ($urandom % 5) == 0;
      loopOpen  = ($urandom % 6) == 0;
      divTest   = ($urandom % 4) != 0;
      pv = 1 + $urandom % 4;
      pr = 1 + $urandom % 4;
      for (int c = 0; c < 150; c++)
        doCycle(($urandom % pv) == 0, ($urandom % pr) == 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule